// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog whose down-counter runs from its own slow clock, separate from the bus clock that software uses to reach it. Software talks to it through four 16-bit registers on a small write-strobe bus with a combinational read port. The registers are a key register, a prescaler register, a reload register and a status register. The counter decrements once per prescaler period. If software lets it reach zero, the block raises a reset request. To keep the system alive, software writes the refresh key at regular intervals, and each such write reloads the counter.

Changes to the reload and prescaler values are guarded by a magic key. A write of the unlock key opens the configuration. Any other key write closes it again. Each accepted configuration write travels to the slow domain through its own toggle handshake. While that handshake is in flight, a busy bit in the status register is set, and the field it guards cannot be written or read. A third handshake, with no status bit, carries the refresh command across.

The block contains two small state machines. The key machine in the bus domain has the states `KEY_LOCKED` and `KEY_OPEN`. It has three transitions:

- `KEY_LOCKED` to `KEY_OPEN` on an unlock-key write.
- `KEY_OPEN` to `KEY_LOCKED` on any other key write.
- Any other state stays where it is.

The counter machine in the slow domain has the states `CNT_RUN` and `CNT_FIRE`. It has two transitions:

- `CNT_RUN` to `CNT_FIRE` when a prescaler tick finds the counter at 1 or 0 and no refresh arrives in the same cycle.
- `CNT_FIRE` to `CNT_RUN` unconditionally after one slow cycle. This transition reloads the counter.

Top module: `wdg_keyed_watchdog`

## Requirements
- R1: After reset, the reload register reads 0xFFF, the prescaler register reads 0, the status register reads 0, and `wdg_rst_req` is low.
- R2: The registers sit at these byte offsets on `bus_addr`:
  - key at 0x0; it is write-only and always reads 0.
  - prescaler at 0x4, value in bits [2:0].
  - reload at 0x8, value in bits [11:0].
  - status at 0xC.
  All other bits read as 0.
- R3: Writes to the reload and prescaler registers take effect only while the block is unlocked. Writing 0x5555 to the key register unlocks it. Any other key value written, including 0xAAAA, locks it again.
- R4: Status bit 1 is the reload busy flag and status bit 0 is the prescaler busy flag.
- R5: An accepted reload or prescaler write sets its busy flag by the next bus cycle. The flag clears within 5 slow-clock cycles.
- R6: While a field's busy flag is 1, writes to that field are ignored and reads of it return 0.
- R7: Writing 0xAAAA to the key register reloads the counter. Refreshing more often than the timeout keeps `wdg_rst_req` low. After a refresh, the first request comes between R·D+1 and R·D+5 slow cycles later, where R is the reload value and D is the division factor.
- R8: The prescaler value n divides the slow clock by 4·2^n for n from 0 to 6. A value of 7 divides by the same factor as 6.
- R9: When the counter reaches zero, `wdg_rst_req` is high for exactly one slow cycle and the counter restarts from the reload value. Without refreshes, requests therefore repeat every max(R,1)·D+1 slow cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| slow_clk | input | 1 | Low-speed counting clock |
| slow_rst_n | input | 1 | Slow-domain asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| wdg_rst_req | output | 1 | Reset request, one slow cycle wide |

## Verification
A key machine stuck in the wrong state shows up on the very next configuration write. In that case a locked write changes the read-back value, or an unlocked write is lost after the busy flag clears. A handshake whose toggles fall out of step leaves a busy flag stuck high, or drops it before the slow side has taken the value. Either fault is visible on the status register within about five slow cycles. A counter or prescaler state error surfaces only at the next reset request: the spacing between two requests shifts away from max(R,1)·D+1, or the request stays high for more than one cycle. For that reason the bench measures request spacing over many reload and prescaler pairs, alongside the register-level checks.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Key machine in the bus domain
    typedef enum logic [0:0] {
        KEY_LOCKED = 1'b0,
        KEY_OPEN   = 1'b1
    } key_state_e;

    // Counter machine in the slow domain
    typedef enum logic [0:0] {
        CNT_RUN  = 1'b0,
        CNT_FIRE = 1'b1
    } cnt_state_e;

    // Register byte offsets
    localparam logic [3:0] OFS_KEY = 4'h0;
    localparam logic [3:0] OFS_PSC = 4'h4;
    localparam logic [3:0] OFS_RLD = 4'h8;
    localparam logic [3:0] OFS_STS = 4'hC;

    // Magic key values
    localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;

    // Crossing channel indices
    localparam int CH_PSC = 0;
    localparam int CH_RLD = 1;
    localparam int CH_RFS = 2;
    localparam int NUM_CH = 3;

endpackage

// File: rtl/wdg_toggle_xfer.sv
// Toggle-based request/acknowledge crossing from a source clock to a
// destination clock. One start pulse yields one destination pulse; busy
// stays high until the destination's acknowledge is synchronised back.
module wdg_toggle_xfer #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_start,
    output logic src_busy,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);

    logic                   req_tgl;
    logic [SYNC_STAGES:0]   dst_sync;
    logic                   ack_tgl;
    logic [SYNC_STAGES-1:0] ack_sync;

    // Source side: a start flips the request toggle when idle
    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            req_tgl <= 1'b0;
        end else if (src_start && !src_busy) begin
            req_tgl <= ~req_tgl;
        end
    end

    // Destination side: synchroniser plus one history stage
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            dst_sync <= '0;
        end else begin
            dst_sync <= {dst_sync[SYNC_STAGES-1:0], req_tgl};
        end
    end

    assign dst_pulse = dst_sync[SYNC_STAGES] ^ dst_sync[SYNC_STAGES-1];
    assign ack_tgl   = dst_sync[SYNC_STAGES];

    // Acknowledge back into the source domain
    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            ack_sync <= '0;
        end else begin
            ack_sync <= {ack_sync[SYNC_STAGES-2:0], ack_tgl};
        end
    end

    assign src_busy = req_tgl ^ ack_sync[SYNC_STAGES-1];

endmodule

// File: rtl/wdg_bus_regs.sv
// Bus-domain register file: key machine, shadow copies of the
// configuration fields, read mux with busy blanking.
module wdg_bus_regs
    import wdg_pkg::*;
#(
    parameter int             RL_W     = 12,
    parameter int             PR_W     = 3,
    parameter logic [RL_W-1:0] RL_RESET = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [3:0]      bus_addr,
    input  logic [15:0]     bus_wdata,
    output logic [15:0]     bus_rdata,
    input  logic            rl_busy,
    input  logic            pr_busy,
    input  logic            rf_busy,
    output logic [RL_W-1:0] rl_shadow,
    output logic [PR_W-1:0] pr_shadow,
    output logic            rl_start,
    output logic            pr_start,
    output logic            rf_start,
    output logic            key_open
);

    key_state_e key_q, key_d;
    logic       key_wr;

    assign key_wr = bus_wr && (bus_addr == OFS_KEY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= KEY_LOCKED;
        end else begin
            key_q <= key_d;
        end
    end

    // Next state: only the unlock key opens, every other key closes
    always_comb begin
        key_d = key_q;
        unique case (key_q)
            KEY_LOCKED: if (key_wr && bus_wdata == KEY_UNLOCK) key_d = KEY_OPEN;
            KEY_OPEN:   if (key_wr && bus_wdata != KEY_UNLOCK) key_d = KEY_LOCKED;
            default:    key_d = KEY_LOCKED;
        endcase
    end

    // Outputs of the key machine and write acceptance
    always_comb begin
        key_open = (key_q == KEY_OPEN);
        rl_start = bus_wr && (bus_addr == OFS_RLD) && key_open && !rl_busy;
        pr_start = bus_wr && (bus_addr == OFS_PSC) && key_open && !pr_busy;
        rf_start = key_wr && (bus_wdata == KEY_REFRESH) && !rf_busy;
    end

    // Shadow configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rl_shadow <= RL_RESET;
            pr_shadow <= '0;
        end else begin
            if (rl_start) rl_shadow <= bus_wdata[RL_W-1:0];
            if (pr_start) pr_shadow <= bus_wdata[PR_W-1:0];
        end
    end

    // Read mux; a field under transfer reads as zero
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_PSC: if (!pr_busy) bus_rdata[PR_W-1:0] = pr_shadow;
            OFS_RLD: if (!rl_busy) bus_rdata[RL_W-1:0] = rl_shadow;
            OFS_STS: bus_rdata[1:0] = {rl_busy, pr_busy};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdg_slow_counter.sv
// Slow-domain prescaler and down-counter with the fire state machine.
module wdg_slow_counter
    import wdg_pkg::*;
#(
    parameter int              RL_W     = 12,
    parameter int              PR_W     = 3,
    parameter int              PR_MAX   = 6,
    parameter int              DIV_LOG2 = 2,
    parameter logic [RL_W-1:0] RL_RESET = '1
) (
    input  logic            slow_clk,
    input  logic            slow_rst_n,
    input  logic            rl_load,
    input  logic [RL_W-1:0] rl_value,
    input  logic            pr_load,
    input  logic [PR_W-1:0] pr_value,
    input  logic            refresh,
    output logic            rst_req,
    output logic [RL_W-1:0] count
);

    localparam int PC_W = DIV_LOG2 + PR_MAX;

    cnt_state_e      state_q, state_d;
    logic [RL_W-1:0] rl_act;
    logic [PR_W-1:0] pr_act;
    logic [PC_W-1:0] presc;
    logic [PC_W-1:0] presc_last;
    logic            tick;

    function automatic logic [PC_W-1:0] last_of(input logic [PR_W-1:0] n);
        int sh;
        sh = DIV_LOG2 + ((int'(n) > PR_MAX) ? PR_MAX : int'(n));
        return PC_W'((32'd1 << sh) - 32'd1);
    endfunction

    assign presc_last = last_of(pr_act);
    assign tick       = (presc >= presc_last);

    // State register
    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) begin
            state_q <= CNT_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_RUN:  if (!refresh && tick && count <= RL_W'(1)) state_d = CNT_FIRE;
            CNT_FIRE: state_d = CNT_RUN;
            default:  state_d = CNT_RUN;
        endcase
    end

    // Datapath: active configuration, prescaler, counter
    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) begin
            rl_act <= RL_RESET;
            pr_act <= '0;
            presc  <= '0;
            count  <= RL_RESET;
        end else begin
            if (rl_load) rl_act <= rl_value;
            if (pr_load) pr_act <= pr_value;
            unique case (state_q)
                CNT_RUN: begin
                    if (refresh) begin
                        count <= rl_act;
                        presc <= '0;
                    end else if (tick) begin
                        presc <= '0;
                        count <= (count <= RL_W'(1)) ? '0 : count - 1'b1;
                    end else begin
                        presc <= presc + 1'b1;
                    end
                end
                CNT_FIRE: begin
                    count <= rl_act;
                    presc <= '0;
                end
                default: begin
                    count <= rl_act;
                    presc <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        rst_req = (state_q == CNT_FIRE);
    end

endmodule

// File: rtl/wdg_keyed_watchdog.sv
module wdg_keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int RL_W        = 12,
    parameter int PR_W        = 3,
    parameter int PR_MAX      = 6,
    parameter int DIV_LOG2    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_clk,
    input  logic        slow_rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        wdg_rst_req
);

    localparam logic [RL_W-1:0] RL_RESET = '1;

    logic [NUM_CH-1:0] xfer_start;
    logic [NUM_CH-1:0] xfer_busy;
    logic [NUM_CH-1:0] xfer_pulse;
    logic [RL_W-1:0]   rl_shadow;
    logic [PR_W-1:0]   pr_shadow;
    logic              rl_start, pr_start, rf_start;
    logic              key_open;
    logic [RL_W-1:0]   slow_count;

    wdg_bus_regs #(
        .RL_W     (RL_W),
        .PR_W     (PR_W),
        .RL_RESET (RL_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rl_busy   (xfer_busy[CH_RLD]),
        .pr_busy   (xfer_busy[CH_PSC]),
        .rf_busy   (xfer_busy[CH_RFS]),
        .rl_shadow (rl_shadow),
        .pr_shadow (pr_shadow),
        .rl_start  (rl_start),
        .pr_start  (pr_start),
        .rf_start  (rf_start),
        .key_open  (key_open)
    );

    always_comb begin
        xfer_start         = '0;
        xfer_start[CH_PSC] = pr_start;
        xfer_start[CH_RLD] = rl_start;
        xfer_start[CH_RFS] = rf_start;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_xfer
        wdg_toggle_xfer #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_xfer (
            .src_clk   (clk),
            .src_rst_n (rst_n),
            .src_start (xfer_start[g]),
            .src_busy  (xfer_busy[g]),
            .dst_clk   (slow_clk),
            .dst_rst_n (slow_rst_n),
            .dst_pulse (xfer_pulse[g])
        );
    end

    wdg_slow_counter #(
        .RL_W     (RL_W),
        .PR_W     (PR_W),
        .PR_MAX   (PR_MAX),
        .DIV_LOG2 (DIV_LOG2),
        .RL_RESET (RL_RESET)
    ) u_cnt (
        .slow_clk   (slow_clk),
        .slow_rst_n (slow_rst_n),
        .rl_load    (xfer_pulse[CH_RLD]),
        .rl_value   (rl_shadow),
        .pr_load    (xfer_pulse[CH_PSC]),
        .pr_value   (pr_shadow),
        .refresh    (xfer_pulse[CH_RFS]),
        .rst_req    (wdg_rst_req),
        .count      (slow_count)
    );

endmodule

// File: rtl/wdg_keyed_watchdog_chk.sv
module wdg_keyed_watchdog_chk
    import wdg_pkg::*;
#(
    parameter int RL_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            slow_clk,
    input logic            slow_rst_n,
    input logic            bus_wr,
    input logic [3:0]      bus_addr,
    input logic [15:0]     bus_wdata,
    input logic [15:0]     bus_rdata,
    input logic            wdg_rst_req,
    input logic            key_open,
    input logic [2:0]      xfer_busy,
    input logic [RL_W-1:0] slow_count
);

    a_r5_rld_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_RLD && key_open && !xfer_busy[CH_RLD]) |=> xfer_busy[CH_RLD]);

    a_r5_psc_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PSC && key_open && !xfer_busy[CH_PSC]) |=> xfer_busy[CH_PSC]);

    a_r3_relock_on_other_key: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_KEY && bus_wdata != KEY_UNLOCK) |=> !key_open);

    a_r3_open_on_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_KEY && bus_wdata == KEY_UNLOCK) |=> key_open);

    a_r6_busy_read_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_RLD && xfer_busy[CH_RLD]) |-> bus_rdata == 16'h0000);

    a_r2_status_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_STS) |-> bus_rdata[15:2] == 14'h0);

    a_r9_single_cycle_request: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        wdg_rst_req |=> !wdg_rst_req);

    a_r9_request_at_zero: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        wdg_rst_req |-> slow_count == '0);

endmodule

bind wdg_keyed_watchdog wdg_keyed_watchdog_chk #(.RL_W(RL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_clk    (slow_clk),
    .slow_rst_n  (slow_rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wdg_rst_req (wdg_rst_req),
    .key_open    (key_open),
    .xfer_busy   (xfer_busy),
    .slow_count  (slow_count)
);

// File: tb/test_wdg_keyed_watchdog.sv
`timescale 1ns/1ps
module test_wdg_keyed_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        slow_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        wdg_rst_req;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    int slow_ticks = 0;
    int rise_cnt = 0;
    int last_rise = 0;
    int prev_rise = 0;
    int wide_cnt = 0;
    logic prev_req = 1'b0;

    always #5 clk = ~clk;
    always #37 slow_clk = ~slow_clk;

    wdg_keyed_watchdog i_wdg_keyed_watchdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_clk    (slow_clk),
        .slow_rst_n  (slow_rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdg_rst_req (wdg_rst_req)
    );

    always @(posedge slow_clk) slow_ticks <= slow_ticks + 1;

    // Reset-request monitor, sampled away from the slow edge
    always @(negedge slow_clk) begin
        if (wdg_rst_req && !prev_req) begin
            prev_rise = last_rise;
            last_rise = slow_ticks;
            rise_cnt  = rise_cnt + 1;
        end
        if (wdg_rst_req && prev_req) wide_cnt = wide_cnt + 1;
        prev_req = wdg_rst_req;
    end

    function automatic int exp_div(input int n);
        return 4 << ((n > 6) ? 6 : n);
    endfunction

    function automatic int exp_period(input int r, input int n);
        return ((r < 1) ? 1 : r) * exp_div(n) + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 200; i++) begin
            bus_read(4'hC, s);
            if (s[1:0] == 2'b00) break;
        end
    endtask

    task automatic configure(input int psc, input int rld);
        bus_write(4'h0, 16'h5555);
        bus_write(4'h4, 16'(psc));
        bus_write(4'h8, 16'(rld));
        wait_idle();
        bus_write(4'h0, 16'hAAAA);
    endtask

    task automatic period_check(input int psc, input int rld, input string req);
        int base;
        configure(psc, rld);
        base = rise_cnt;
        wait (rise_cnt >= base + 2);
        check(last_rise - prev_rise == exp_period(rld, psc), req,
              last_rise - prev_rise, exp_period(rld, psc));
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=0x0 expected=0x1 (run did not finish)");
            report();
        end
    end

    initial begin
        logic [15:0] d;
        int t0;
        int base;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        slow_rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        bus_read(4'h8, d); check(d == 16'h0FFF, "R1 reload reset", d, 16'h0FFF);
        bus_read(4'h4, d); check(d == 16'h0000, "R1 prescaler reset", d, 0);
        bus_read(4'hC, d); check(d == 16'h0000, "R1/R4 status reset", d, 0);
        check(wdg_rst_req == 1'b0, "R1 request low", wdg_rst_req, 0);

        // R3: locked write ignored
        bus_write(4'h8, 16'h0123);
        bus_read(4'hC, d); check(d == 16'h0000, "R3 locked write no busy", d, 0);
        bus_read(4'h8, d); check(d == 16'h0FFF, "R3 locked write ignored", d, 16'h0FFF);

        // R2: key reads zero
        bus_read(4'h0, d); check(d == 16'h0000, "R2 key reads zero", d, 0);

        // R4/R5/R6: reload update, busy flag, blanked read, write while busy
        bus_write(4'h0, 16'h5555);
        t0 = slow_ticks;
        bus_write(4'h8, 16'hF123);
        bus_read(4'hC, d); check(d == 16'h0002, "R4 R5 reload busy set", d, 2);
        bus_read(4'h8, d); check(d == 16'h0000, "R6 busy read blank", d, 0);
        bus_write(4'h8, 16'h0456);
        wait_idle();
        check(slow_ticks - t0 <= 5, "R5 busy clear within 5 slow cycles", slow_ticks - t0, 5);
        bus_read(4'h8, d); check(d == 16'h0123, "R2 R6 reload value and reserved bits", d, 16'h0123);

        // R4/R2: prescaler busy bit and width
        bus_write(4'h4, 16'hFFFF);
        bus_read(4'hC, d); check(d == 16'h0001, "R4 prescaler busy bit", d, 1);
        bus_read(4'h4, d); check(d == 16'h0000, "R6 prescaler busy read blank", d, 0);
        wait_idle();
        bus_read(4'h4, d); check(d == 16'h0007, "R2 prescaler field", d, 7);

        // R3: other key cancels unlock
        bus_write(4'h0, 16'h5555);
        bus_write(4'h0, 16'h1234);
        bus_write(4'h8, 16'h0777);
        bus_read(4'h8, d); check(d == 16'h0123, "R3 other key relocks", d, 16'h0123);
        bus_write(4'h0, 16'h5555);
        bus_write(4'h0, 16'hAAAA);
        bus_write(4'h4, 16'h0002);
        bus_read(4'h4, d); check(d == 16'h0007, "R3 refresh key relocks", d, 7);

        // R8/R9: directed periods
        period_check(1, 10, "R8 R9 div8 period");
        check(wide_cnt == 0, "R9 one-cycle request", wide_cnt, 0);
        period_check(0, 0, "R9 reload zero period");
        period_check(6, 2, "R8 div256 period");
        period_check(7, 2, "R8 prescaler 7 same as 6");

        // R8/R9: random reload/prescaler pairs
        for (int k = 0; k < 5; k++) begin
            int rp, rr;
            rp = int'($urandom_range(3, 0));
            rr = int'($urandom_range(12, 0));
            period_check(rp, rr, "R8 R9 random period");
        end

        // R7: periodic refresh prevents requests, then timeout latency
        configure(0, 20);
        repeat (8) @(posedge slow_clk);
        base = rise_cnt;
        for (int k = 0; k < 10; k++) begin
            repeat (40) @(posedge slow_clk);
            bus_write(4'h0, 16'hAAAA);
        end
        t0 = slow_ticks;
        check(rise_cnt == base, "R7 refresh keeps request low", rise_cnt - base, 0);
        wait (rise_cnt > base);
        check((last_rise - t0 >= 81) && (last_rise - t0 <= 85), "R7 timeout after refresh",
              last_rise - t0, 81);
        check(wide_cnt == 0, "R9 request width overall", wide_cnt, 0);

        done = 1'b1;
        report();
    end

endmodule